// File: doc/BRIEF.md
# Lockup-Free Pseudo-Random Shift Sequence Generator

This block produces a pseudo-random bit sequence from a linear feedback shift register of parameterizable width, using XOR feedback in the Fibonacci arrangement. A plain XOR-feedback register that ever holds all zeros maps that state onto itself and stalls for good. This block rules that out in two ways, and a mode input picks one of them on each step.

In recovery mode, a detector watches for the all-zeros state at any time, not only after reset. When it sees it, the detector forces a one into the incoming bit and raises a single-cycle correction flag. The cycle is then the usual 2^N-1 states and never contains zero. In full-cycle mode, the feedback is bent so that all zeros sits between 10...0 and 0...01, which gives a cycle of exactly 2^N states with no stuck state at all.

The register shifts toward the MSB and the new bit enters at the LSB. The serial output is the MSB. Reset loads the nonzero seed 0...01.

Top module: `lfsr_lockfree`

## Requirements
- R1: While reset is asserted, and after its release until the first enabled step, `state` is 0...01 (8'h01 by default), `serial_out` is 0 and `fix_pulse` is 0.
- R2: On an edge where `en` is 0, `state` keeps its value and `fix_pulse` is 0 in the following cycle. This holds even when `state` is all zeros.
- R3: On an enabled edge, `state` becomes {state[N-2:0], fb}. With the default taps, fb is state[7]^state[5]^state[4]^state[3] (tap mask 8'hB8), apart from the corrections in R4 and R6. `serial_out` always equals state[N-1].
- R4: In recovery mode (`mode_sel`=0), an enabled edge with `state` all zeros loads 0...01, and `fix_pulse` is 1 for exactly the following cycle.
- R5: In recovery mode from the seed, `state` returns to the seed after exactly 2^N-1 = 255 enabled steps and never passes through zero.
- R6: In full-cycle mode (`mode_sel`=1), 10...0 steps to all zeros and all zeros steps to 0...01. The seed recurs after exactly 2^N = 256 steps, and zero is visited once.
- R7: `fix_pulse` is never 1 after an edge taken in full-cycle mode, including the step out of all zeros.
- R8: `mode_sel` may change on any cycle. Each step uses the mode value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously inside the block |
| en | input | 1 | Step enable |
| mode_sel | input | 1 | 0 = recovery mode, 1 = full-cycle mode |
| state | output | WIDTH | Parallel register contents |
| serial_out | output | 1 | Serial output bit (register MSB) |
| fix_pulse | output | 1 | One-cycle flag after a zero-state correction in recovery mode |

## Verification
The properties assume that `en` and `mode_sel` change only between clock edges. They also assume that nothing is judged while the internally synchronised reset is still active, so every check that refers to a past step requires that reset was already released at that step. The bench drives inputs one time unit after each rising edge and keeps `en` low through reset and the synchronizer delay. It reaches the all-zeros state only through full-cycle mode, and then switches to recovery mode while the register is zero, so the correction path is exercised through the ports alone.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic {
    MODE_RECOVER = 1'b0,
    MODE_FULL    = 1'b1
  } lfsr_mode_e;

  localparam int unsigned DEF_WIDTH = 8;
  // x^8 + x^6 + x^5 + x^4 + 1 as a mask over state bits 7,5,4,3
  localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 8'hB8;
endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lfsr_next.sv
module lfsr_next
  import lfsr_pkg::*;
#(
  parameter int unsigned     WIDTH = DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = DEF_TAPS
) (
  input  logic [WIDTH-1:0] cur,
  input  lfsr_mode_e       mode,
  output logic [WIDTH-1:0] nxt,
  output logic             fix
);
  localparam int unsigned LOW = WIDTH - 1;

  logic all_zero;
  logic low_zero;
  logic fb_lin;
  logic fb;

  always_comb begin
    all_zero = ~|cur;
    low_zero = ~|cur[LOW-1:0];
    fb_lin   = ^(cur & TAPS);
    case (mode)
      MODE_FULL: begin
        // splice zero between 10..0 and 0..01
        fb  = fb_lin ^ low_zero;
        fix = 1'b0;
      end
      default: begin
        fb  = fb_lin | all_zero;
        fix = all_zero;
      end
    endcase
    nxt = {cur[LOW-1:0], fb};
  end
endmodule

// File: rtl/lfsr_lockfree.sv
module lfsr_lockfree
  import lfsr_pkg::*;
#(
  parameter int unsigned      WIDTH       = DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS        = DEF_TAPS,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_sel,
  output logic [WIDTH-1:0] state,
  output logic             serial_out,
  output logic             fix_pulse
);
  localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic             rst_core_n;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             fix_d;
  logic             flag_q;
  logic             flag_d;
  lfsr_mode_e       mode_e;

  lfsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign mode_e = lfsr_mode_e'(mode_sel);

  lfsr_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
    .cur  (state_q),
    .mode (mode_e),
    .nxt  (state_d),
    .fix  (fix_d)
  );

  always_comb begin
    flag_d = en & fix_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= SEED;
      flag_q  <= 1'b0;
    end else begin
      if (en) state_q <= state_d;
      flag_q <= flag_d;
    end
  end

  assign state      = state_q;
  assign serial_out = state_q[WIDTH-1];
  assign fix_pulse  = flag_q;
endmodule

// File: rtl/lfsr_lockfree_chk.sv
module lfsr_lockfree_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode_sel,
  input logic [WIDTH-1:0] state,
  input logic             serial_out,
  input logic             fix_pulse
);
  localparam logic [WIDTH-1:0] TOP_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] LSB_ONLY = {{(WIDTH-1){1'b0}}, 1'b1};

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && !en) |-> ($stable(state) && !fix_pulse));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en) |-> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

  assert_serial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(serial_out) |-> $changed(state));

  assert_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && !mode_sel && (state == '0)) |-> (fix_pulse && state == LSB_ONLY));

  assert_no_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && !mode_sel && (state != '0)) |-> (state != '0));

  assert_splice_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && mode_sel && (state == TOP_ONLY)) |-> (state == '0));

  assert_full_noflag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && mode_sel) |-> !fix_pulse);
endmodule

bind lfsr_lockfree lfsr_lockfree_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .en         (en),
  .mode_sel   (mode_sel),
  .state      (state),
  .serial_out (serial_out),
  .fix_pulse  (fix_pulse)
);

// File: tb/lfsr_lockfree_tb.sv
`timescale 1ns/1ps
module lfsr_lockfree_tb;
  localparam int W = 8;
  localparam int NSEG = 6;
  // segment: {mode, en, length}
  localparam logic [11:0] SEG [NSEG] = '{
    {1'b0, 1'b1, 10'd20},
    {1'b0, 1'b0, 10'd5},
    {1'b1, 1'b1, 10'd30},
    {1'b1, 1'b0, 10'd3},
    {1'b0, 1'b1, 10'd12},
    {1'b1, 1'b1, 10'd7}
  };

  logic clk = 1'b0;
  logic rst_n, en, mode_sel;
  logic [W-1:0] state;
  logic serial_out, fix_pulse;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] exp_s;
  logic exp_f;

  always #2.5 clk = ~clk;

  lfsr_lockfree u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel),
    .state(state), .serial_out(serial_out), .fix_pulse(fix_pulse)
  );

  function automatic logic [W-1:0] model_next(input logic [W-1:0] s, input logic full);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    if (full) begin
      if (s[6:0] == 7'd0) fb = ~fb;
    end else if (s == '0) begin
      fb = 1'b1;
    end
    return {s[6:0], fb};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; en = 1'b0; mode_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 state in reset", state, 8'h01);
    check("R1 serial in reset", {7'd0, serial_out}, 8'h00);
    check("R1 flag in reset", {7'd0, fix_pulse}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 state after release", state, 8'h01);
    exp_s = 8'h01;
    exp_f = 1'b0;
  endtask

  task automatic step(input logic m, input logic e);
    mode_sel = m; en = e;
    @(posedge clk);
    #1;
    exp_f = e & ~m & (exp_s == '0);
    if (e) exp_s = model_next(exp_s, m);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    do_reset();

    // table walk: R3 stepping, R2 hold, R8 mode switching between segments
    for (int g = 0; g < NSEG; g++) begin
      for (int i = 0; i < int'(SEG[g][9:0]); i++) begin
        step(SEG[g][11], SEG[g][10]);
        check(SEG[g][10] ? "R3/R8 state" : "R2 hold", state, exp_s);
        check("R3 serial", {7'd0, serial_out}, {7'd0, exp_s[7]});
        check(SEG[g][11] ? "R7 flag" : "R4 flag", {7'd0, fix_pulse}, {7'd0, exp_f});
      end
    end

    // R5: recovery period from the seed
    do_reset();
    begin
      int n = 0;
      int zeros = 0;
      do begin
        step(1'b0, 1'b1);
        n++;
        if (state == '0) zeros++;
      end while (state != 8'h01 && n < 400);
      check("R5 period", n[7:0], 8'd255);
      check("R5 period high bits", {7'd0, n[8]}, 8'd0);
      check("R5 zero visits", zeros[7:0], 8'd0);
    end

    // R6/R7: full-cycle period and zero splice
    do_reset();
    begin
      int n = 0;
      int zeros = 0;
      int flags = 0;
      logic [W-1:0] prev;
      logic saw_splice = 1'b0;
      do begin
        prev = state;
        step(1'b1, 1'b1);
        n++;
        if (fix_pulse) flags++;
        if (state == '0) begin
          zeros++;
          if (prev == 8'h80) saw_splice = 1'b1;
        end
      end while (state != 8'h01 && n < 400);
      check("R6 period", n[8:1], 8'd128);
      check("R6 period lsb", {7'd0, n[0]}, 8'd0);
      check("R6 zero visits", zeros[7:0], 8'd1);
      check("R6 entry from 10..0", {7'd0, saw_splice}, 8'd1);
      check("R7 no flag in full mode", flags[7:0], 8'd0);
    end

    // R4/R2: reach zero in full mode, hold, then recover
    do_reset();
    for (int i = 0; i < 255; i++) step(1'b1, 1'b1);
    check("R6 zero after 255 steps", state, 8'h00);
    check("R7 flag low leaving 10..0", {7'd0, fix_pulse}, 8'd0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    check("R2 zero held with en low", state, 8'h00);
    check("R2 no flag with en low", {7'd0, fix_pulse}, 8'd0);
    step(1'b0, 1'b1);
    check("R4 recovered state", state, 8'h01);
    check("R4 flag raised", {7'd0, fix_pulse}, 8'd1);
    step(1'b0, 1'b1);
    check("R4 flag one cycle", {7'd0, fix_pulse}, 8'd0);
    check("R3 step after recovery", state, exp_s);

    // R7: zero to seed in full mode raises no flag
    do_reset();
    for (int i = 0; i < 255; i++) step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check("R6 zero to seed", state, 8'h01);
    check("R7 no flag leaving zero", {7'd0, fix_pulse}, 8'd0);

    report();
    $finish;
  end
endmodule